// File: doc/BRIEF.md
# Bus-Side SEC-DED Error Detection and Correction Unit

This unit sits between a processor bus and a memory that stores 22 bits per location: a 16-bit data word and a 6-bit check word. During a write, it computes the check word from the data on the bus and drives it toward memory. During a read, it takes the stored data and check word in, holds them, and reports whether the pair is clean, has one flipped bit, or has two flipped bits. In its correction phase, it drives the repaired data word back onto the bus and returns the syndrome on the check-word port.

Each data bit is covered by exactly three of the six check bits, and no two data bits share the same set of three. A check bit is the even parity of the data bits assigned to it. The syndrome is active-low: a syndrome bit is low when the stored check bit and the recomputed check bit differ, so a syndrome of all ones means no error. A single error in a data bit produces the three-low pattern of that bit and is corrected. A single error in a check bit produces one low bit and is flagged, but the data word is left unchanged. Any two errors produce an even number of low bits and raise both flags, with no correction.

The two bidirectional ports are modelled as separate input, output and output-enable signals. A two-bit mode input selects the phase. The stored pair is captured on each clock edge while the mode is read, and it stays frozen in the other modes.

Top module: `edac_unit`

## Requirements
- R1: In write mode (mode = 2'b00), `chk_out` equals the six parities of `data_in`, `chk_oe` is 1 and `data_oe` is 0. Check bit k is the XOR of the data bits whose column contains k.
- R2: In read mode (mode = 2'b01), both output enables are 0, and the data/check latch loads `data_in` and `chk_in` on every rising clock edge.
- R3: In modes 2'b11 and 2'b10, the latch holds its contents whatever `data_in` and `chk_in` do, so the flags, `data_out` and `chk_out` stay steady.
- R4: When the latched pair is consistent, the syndrome is 6'h3F and both flags are 0 in modes 2'b11 and 2'b10.
- R5: Each data bit has a fixed set of three check bits (its column):
  - bits 0 to 7: {0,1,3}, {0,2,3}, {1,2,3}, {0,1,4}, {0,2,4}, {1,2,4}, {1,3,4}, {2,3,4}
  - bits 8 to 15: {0,1,5}, {0,2,5}, {0,3,5}, {1,3,5}, {2,3,5}, {0,4,5}, {1,4,5}, {2,4,5}

  When one data bit is wrong, exactly its three syndrome bits are low, the single flag is 1, the double flag is 0, and `data_out` carries the corrected word.
- R6: When exactly one check bit k is wrong, only syndrome bit k is low, the single flag is 1, the double flag is 0, and `data_out` equals the latched data unchanged.
- R7: When two bits are wrong (two data bits, two check bits, or one of each), both flags are 1 and `data_out` equals the latched data without correction. Any nonzero syndrome that is neither one low bit nor a data column is classified this way.
- R8: In modes 2'b00 and 2'b01, both flags are 0 whatever the latch holds.
- R9: In correct mode (mode = 2'b10), `data_oe` and `chk_oe` are 1 and `chk_out` carries the active-low syndrome.
- R10: After synchronous active-low reset, the latch holds zero data and a zero check word. The syndrome is then 6'h3F and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 2 | Phase select: 00 write, 01 read, 11 latch/flag, 10 correct |
| data_in | input | 16 | Data word from bus (write) or memory (read) |
| data_out | output | 16 | Corrected data word |
| data_oe | output | 1 | Enable for driving data_out |
| chk_in | input | 6 | Stored check word from memory |
| chk_out | output | 6 | Check word (write) or syndrome (correct) |
| chk_oe | output | 1 | Enable for driving chk_out |
| single_err | output | 1 | At least one error detected |
| double_err | output | 1 | Uncorrectable multiple error detected |

## Verification
The bench builds the unit with its default widths: 16 data bits and 6 check bits. This makes the whole single-error space reachable: every one of the sixteen data columns and every one of the six check bits is flipped in turn. It also covers representative two-error mixes and checks that the latch stays frozen while the inputs toggle in the flag and correct phases. Expected syndromes and check words come from a column table written in the bench from the requirements.

// File: rtl/edac_pkg.sv
// Shared constants, phase encoding and the column code of every data bit.
// Assumes a 16-bit data word protected by a 6-bit check word.
package edac_pkg;

    localparam int DATA_W = 16;
    localparam int CHK_W  = 6;

    typedef enum logic [1:0] {
        PH_WRITE   = 2'b00,
        PH_READ    = 2'b01,
        PH_CORRECT = 2'b10,
        PH_LATCH   = 2'b11
    } edac_phase_e;

    // Returns the set of check bits (bit k set = check bit k) covering data bit idx.
    function automatic logic [CHK_W-1:0] column_of(input int idx);
        logic [CHK_W-1:0] col;
        case (idx)
            0:  col = 6'b001011;
            1:  col = 6'b001101;
            2:  col = 6'b001110;
            3:  col = 6'b010011;
            4:  col = 6'b010101;
            5:  col = 6'b010110;
            6:  col = 6'b011010;
            7:  col = 6'b011100;
            8:  col = 6'b100011;
            9:  col = 6'b100101;
            10: col = 6'b101001;
            11: col = 6'b101010;
            12: col = 6'b101100;
            13: col = 6'b110001;
            14: col = 6'b110010;
            15: col = 6'b110100;
            default: col = '0;
        endcase
        return col;
    endfunction

endpackage

// File: rtl/edac_chkgen.sv
// Check-word generator: each output bit is the even parity of the data bits
// whose column includes it. Purely combinational; assumes the column table
// in edac_pkg.
module edac_chkgen
    import edac_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int CW = CHK_W
) (
    input  logic [DW-1:0] data,
    output logic [CW-1:0] check
);

    for (genvar k = 0; k < CW; k++) begin : g_bit
        logic acc;
        // Fold the data bits assigned to check bit k into one parity bit.
        always_comb begin
            logic [CW-1:0] col;
            acc = 1'b0;
            for (int i = 0; i < DW; i++) begin
                col = column_of(i);
                if (col[k]) acc = acc ^ data[i];
            end
        end
        assign check[k] = acc;
    end

endmodule

// File: rtl/edac_classify.sv
// Syndrome decoder: turns the stored/recomputed difference into the
// active-low syndrome, a per-bit correction mask and the error class.
// Assumes distinct weight-3 data columns, so any two errors give an even
// nonzero difference.
module edac_classify
    import edac_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int CW = CHK_W
) (
    input  logic [CW-1:0] stored_chk,
    input  logic [CW-1:0] recomputed_chk,
    output logic [CW-1:0] syndrome_n,
    output logic [DW-1:0] flip_mask,
    output logic          any_err,
    output logic          multi_err
);

    logic [CW-1:0] diff;
    logic          chk_only;
    logic          data_hit;

    // Difference vector: high where a check bit disagrees.
    always_comb diff = stored_chk ^ recomputed_chk;

    assign syndrome_n = ~diff;

    for (genvar i = 0; i < DW; i++) begin : g_col
        // Mark data bit i for correction when the difference equals its column.
        always_comb flip_mask[i] = (diff == column_of(i));
    end

    // Classify the difference into none / single / multiple.
    always_comb begin
        any_err   = |diff;
        chk_only  = ($countones(diff) == 1);
        data_hit  = |flip_mask;
        multi_err = any_err && !chk_only && !data_hit;
    end

endmodule

// File: rtl/edac_correct.sv
// Data repair stage: inverts the data bits selected by the correction mask.
// Assumes the mask has at most one bit set.
module edac_correct
    import edac_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic [DW-1:0] raw_data,
    input  logic [DW-1:0] flip_mask,
    output logic [DW-1:0] fixed_data
);

    for (genvar i = 0; i < DW; i++) begin : g_fix
        // Invert bit i only when the syndrome points at it.
        always_comb fixed_data[i] = raw_data[i] ^ flip_mask[i];
    end

endmodule

// File: rtl/edac_unit.sv
// Top of the error detection and correction unit. Phase 00 generates a
// check word from the bus. Phase 01 captures the memory word on every edge.
// Phase 11 holds the capture and raises the flags. Phase 10 additionally
// drives the corrected data and the syndrome. Assumes the pads outside
// honour the output enables.
module edac_unit
    import edac_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int CW = CHK_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    mode,
    input  logic [DW-1:0] data_in,
    output logic [DW-1:0] data_out,
    output logic          data_oe,
    input  logic [CW-1:0] chk_in,
    output logic [CW-1:0] chk_out,
    output logic          chk_oe,
    output logic          single_err,
    output logic          double_err
);

    edac_phase_e   phase;
    logic [DW-1:0] held_data;
    logic [CW-1:0] held_chk;
    logic [CW-1:0] bus_chk;
    logic [CW-1:0] held_recalc;
    logic [CW-1:0] syn_n;
    logic [DW-1:0] flip;
    logic [DW-1:0] repaired;
    logic          err_any;
    logic          err_multi;
    logic          flags_live;

    assign phase = edac_phase_e'(mode);

    // Capture the stored word while in read phase; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_data <= '0;
            held_chk  <= '0;
        end else if (phase == PH_READ) begin
            held_data <= data_in;
            held_chk  <= chk_in;
        end
    end

    edac_chkgen #(.DW(DW), .CW(CW)) u_gen_bus (
        .data  (data_in),
        .check (bus_chk)
    );

    edac_chkgen #(.DW(DW), .CW(CW)) u_gen_held (
        .data  (held_data),
        .check (held_recalc)
    );

    edac_classify #(.DW(DW), .CW(CW)) u_classify (
        .stored_chk     (held_chk),
        .recomputed_chk (held_recalc),
        .syndrome_n     (syn_n),
        .flip_mask      (flip),
        .any_err        (err_any),
        .multi_err      (err_multi)
    );

    edac_correct #(.DW(DW)) u_correct (
        .raw_data   (held_data),
        .flip_mask  (flip),
        .fixed_data (repaired)
    );

    // Flags are live only in the latch and correct phases.
    always_comb flags_live = (phase == PH_LATCH) || (phase == PH_CORRECT);

    // Drive flags, enables and the two output buses per phase.
    always_comb begin
        single_err = flags_live && err_any;
        double_err = flags_live && err_multi;
        data_out   = repaired;
        data_oe    = (phase == PH_CORRECT);
        chk_oe     = (phase == PH_WRITE) || (phase == PH_CORRECT);
        chk_out    = (phase == PH_WRITE) ? bus_chk : syn_n;
    end

endmodule

// File: rtl/edac_unit_chk.sv
// Property checker for edac_unit, attached through bind. Observes ports only.
module edac_unit_chk #(
    parameter int DW = 16,
    parameter int CW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    mode,
    input logic [DW-1:0] data_out,
    input logic          data_oe,
    input logic [CW-1:0] chk_out,
    input logic          chk_oe,
    input logic          single_err,
    input logic          double_err
);

    // R8
    flags_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode[1] == 1'b0) |-> (!single_err && !double_err));

    // R7
    double_has_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        double_err |-> single_err);

    // R1
    write_enables_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00) |-> (chk_oe && !data_oe));

    // R9
    correct_enables_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b10) |-> (chk_oe && data_oe));

    // R3
    correct_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b10 && $past(mode) == 2'b10 && $past(rst_n))
            |-> ($stable(data_out) && $stable(chk_out) && $stable(single_err)));

    // R4
    clean_syndrome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b10 && chk_out == {CW{1'b1}}) |-> !single_err);

    // R6
    single_weight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b10 && single_err && !double_err)
            |-> ($countones(~chk_out) == 1 || $countones(~chk_out) == 3));

endmodule

bind edac_unit edac_unit_chk #(.DW(DW), .CW(CW)) chk_i (.*);

// File: tb/edac_unit_tb_top.sv
// Scoreboard bench: the driver pushes expected correct-phase results into a
// queue and the monitor pops and compares them when signalled.
module edac_unit_tb_top;

    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [15:0] exp_data;
        logic [5:0]  exp_syn;
        logic        exp_sef;
        logic        exp_def;
        string       tag;
    } exp_item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode = 2'b11;
    logic [15:0] data_in = '0;
    logic [15:0] data_out;
    logic        data_oe;
    logic [5:0]  chk_in = '0;
    logic [5:0]  chk_out;
    logic        chk_oe;
    logic        single_err;
    logic        double_err;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;
    exp_item_t exp_q[$];
    event sample_ev;

    logic [5:0] cols [16] = '{6'b001011, 6'b001101, 6'b001110, 6'b010011,
                              6'b010101, 6'b010110, 6'b011010, 6'b011100,
                              6'b100011, 6'b100101, 6'b101001, 6'b101010,
                              6'b101100, 6'b110001, 6'b110010, 6'b110100};

    always #(CLK_PERIOD/2) clk = ~clk;

    edac_unit dut_i (
        .clk(clk), .rst_n(rst_n), .mode(mode),
        .data_in(data_in), .data_out(data_out), .data_oe(data_oe),
        .chk_in(chk_in), .chk_out(chk_out), .chk_oe(chk_oe),
        .single_err(single_err), .double_err(double_err)
    );

    function automatic logic [5:0] ref_chk(input logic [15:0] d);
        logic [5:0] c = '0;
        for (int i = 0; i < 16; i++) if (d[i]) c = c ^ cols[i];
        return c;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // Load a stored pair, check flags in latch phase, then queue the correct-phase result.
    task automatic run_case(input logic [15:0] sd, input logic [5:0] sc,
                            input logic [15:0] ed, input logic sef, input logic def,
                            input string tag);
        exp_item_t it;
        @(negedge clk);
        mode = 2'b01; data_in = sd; chk_in = sc;
        @(negedge clk);
        // R8: flags quiet in read phase even with an error latched
        check(!single_err && !double_err, {tag, " R8 read flags"},
              {30'd0, single_err, double_err}, 32'd0);
        mode = 2'b11; data_in = ~sd; chk_in = ~sc;
        #1;
        check(single_err == sef && double_err == def, {tag, " latch flags"},
              {30'd0, single_err, double_err}, {30'd0, sef, def});
        @(negedge clk);
        mode = 2'b10; data_in = sd ^ 16'h5A5A;
        #1;
        it.exp_data = ed;
        it.exp_syn  = ~(sc ^ ref_chk(sd));
        it.exp_sef  = sef;
        it.exp_def  = def;
        it.tag      = tag;
        exp_q.push_back(it);
        -> sample_ev;
        @(negedge clk);
    endtask

    // Monitor: compare the correct-phase outputs against the queued expectation.
    initial begin
        forever begin
            exp_item_t it;
            @(sample_ev);
            if (exp_q.size() == 0) begin
                check(1'b0, "scoreboard empty", 32'd0, 32'd1);
            end else begin
                it = exp_q.pop_front();
                check(data_oe && chk_oe, {it.tag, " R9 enables"},
                      {30'd0, data_oe, chk_oe}, 32'd3);
                check(chk_out == it.exp_syn, {it.tag, " R9 syndrome"},
                      {26'd0, chk_out}, {26'd0, it.exp_syn});
                check(data_out == it.exp_data, {it.tag, " data"},
                      {16'd0, data_out}, {16'd0, it.exp_data});
                check(single_err == it.exp_sef && double_err == it.exp_def,
                      {it.tag, " correct flags"}, {30'd0, single_err, double_err},
                      {30'd0, it.exp_sef, it.exp_def});
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [15:0] pats [4] = '{16'h0000, 16'hFFFF, 16'hA5C3, 16'h1234};
        logic [15:0] base;

        // R10: reset state, latch holds zeros
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(!single_err && !double_err, "R10 reset flags",
              {30'd0, single_err, double_err}, 32'd0);
        @(negedge clk);
        mode = 2'b10;
        #1;
        check(chk_out == 6'h3F && data_out == 16'h0000, "R10 reset syndrome/data",
              {10'd0, chk_out, data_out}, {10'd0, 6'h3F, 16'h0000});

        // R2: read phase leaves both buses undriven
        @(negedge clk);
        mode = 2'b01;
        #1;
        check(!data_oe && !chk_oe, "R2 read enables", {30'd0, data_oe, chk_oe}, 32'd0);

        // R1: write phase check word generation
        foreach (pats[p]) begin
            @(negedge clk);
            mode = 2'b00; data_in = pats[p];
            #1;
            check(chk_out == ref_chk(pats[p]) && chk_oe && !data_oe, "R1 write check word",
                  {24'd0, chk_oe, data_oe, chk_out}, {24'd0, 2'b10, ref_chk(pats[p])});
            check(!single_err && !double_err, "R8 write flags",
                  {30'd0, single_err, double_err}, 32'd0);
        end

        // R4: clean words
        foreach (pats[p]) run_case(pats[p], ref_chk(pats[p]), pats[p], 1'b0, 1'b0, "R4 clean");

        // R5: every single data-bit error
        base = 16'hC35A;
        for (int i = 0; i < 16; i++)
            run_case(base ^ (16'h1 << i), ref_chk(base), base, 1'b1, 1'b0, "R5 data bit");

        // R6: every single check-bit error
        for (int k = 0; k < 6; k++)
            run_case(base, ref_chk(base) ^ (6'h1 << k), base, 1'b1, 1'b0, "R6 check bit");

        // R7: double errors, data left uncorrected
        run_case(base ^ 16'h0003, ref_chk(base), base ^ 16'h0003, 1'b1, 1'b1, "R7 two data");
        run_case(base ^ 16'h8000, ref_chk(base) ^ 6'h01, base ^ 16'h8000, 1'b1, 1'b1, "R7 data+check");
        run_case(base, ref_chk(base) ^ 6'h30, base, 1'b1, 1'b1, "R7 two check");
        run_case(16'h0000, 6'h07, 16'h0000, 1'b1, 1'b1, "R7 unused weight3");

        // R3: latch holds across many toggling cycles in correct phase
        @(negedge clk);
        mode = 2'b01; data_in = base ^ 16'h0010; chk_in = ref_chk(base);
        @(negedge clk);
        mode = 2'b10;
        for (int n = 0; n < 4; n++) begin
            data_in = $urandom; chk_in = 6'($urandom);
            @(negedge clk);
            check(data_out == base && chk_out == ~cols[4], "R3 hold",
                  {10'd0, chk_out, data_out}, {10'd0, ~cols[4], base});
        end

        repeat (2) @(negedge clk);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule